// File: doc/BRIEF.md
# Single-Cycle Six-Instruction RISC Core

This block is a 32-bit processor core that finishes every instruction in the clock cycle that fetches it. It handles six operations: register add, register subtract, OR with a 16-bit immediate, word load, word store and branch-if-equal. The program counter addresses a combinational instruction-memory read port. A single data-memory port carries the address, the write data, a write strobe and the read data. A decoder turns the opcode and function fields into one control word. That word steers a shared datapath made of a 32-entry register file, an immediate extender, a three-function ALU with a zero flag, and the operand and write-back selectors.

The core is intended as the execute engine of a small embedded controller, where the instruction store and the data store sit beside it as plain arrays. All state changes on the rising clock edge. A result written by one instruction is therefore visible to the instruction in the next cycle. The OR immediate zero-extends its constant. Memory offsets and branch displacements are sign-extended.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is cleared to 0 and every register is cleared to 0. During reset `imem_addr` reads 0 and `dmem_we` is low.
- R2: `imem_addr` is always the PC. Every instruction other than a taken branch advances the PC by 4.
- R3: Opcode 0x00 with function 0x21 writes the 32-bit wrapped sum of registers rs and rt into register rd. Function 0x23 writes the wrapped difference rs minus rt into rd. The result is visible to the next instruction. Fields are op[31:26], rs[25:21], rt[20:16], rd[15:11], function[5:0] and imm[15:0].
- R4: Opcode 0x0D writes register rs OR the zero-extended imm[15:0] into register rt.
- R5: Opcode 0x23 drives `dmem_addr` with register rs plus the sign-extended imm, with bits [1:0] forced to 0. It writes `dmem_rdata` into register rt and keeps `dmem_we` low.
- R6: Opcode 0x2B drives the same address as R5, raises `dmem_we` for that cycle and drives register rt on `dmem_wdata`. No register is written.
- R7: Opcode 0x04 writes nothing. If registers rs and rt are equal, the next PC is PC + 4 + (sign-extended imm shifted left by 2). Otherwise the next PC is PC + 4.
- R8: Register 0 always reads as 0, and writes to it are dropped.
- R9: Any other opcode, or opcode 0x00 with any other function code, writes neither a register nor memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, returned combinationally |
| dmem_addr | output | 32 | Word-aligned byte address for a load or store |
| dmem_wdata | output | 32 | Data to write during a store |
| dmem_we | output | 1 | Write strobe, high for one cycle during a store |
| dmem_rdata | input | 32 | Word read at `dmem_addr`, returned combinationally |

## Verification
The hardest case to reach from the ports is a register value that only becomes observable several instructions after it was produced. The prime examples are a dropped write to register 0 and a write that an unknown opcode must not perform, since neither shows up on any port when it happens. The stimulus handles this by ending each directed sequence with stores and branches that read the affected registers. It also generates random programs over eight registers, so most values are consumed soon after they are written. A lockstep model in the bench records which requirement produced each register's current value and names that requirement when a later store exposes a mismatch. Taken backward branches are reached with random displacements. Fresh programs after each reset keep tight loops from consuming the run.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN = 32;
  localparam int IMMW = 16;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADD   = 6'h21;
  localparam logic [5:0] FN_SUB   = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;     // 1: write rd, 0: write rt
    logic    b_imm;      // 1: ALU B is extended immediate
    logic    ext_sign;   // 1: sign-extend, 0: zero-extend
    alu_op_e alu_op;
    logic    mem_wr;
    logic    wb_mem;     // 1: write back load data
    logic    reg_wr;
    logic    is_branch;
  } ctrl_t;

  function automatic logic [XLEN-1:0] extend_imm(input logic [IMMW-1:0] imm,
                                                 input logic sgn);
    return sgn ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm}
               : {{(XLEN-IMMW){1'b0}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_SUB: return a - b;
      ALU_OR:  return a | b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] next_pc(input logic [XLEN-1:0] pc,
                                              input logic take,
                                              input logic [XLEN-1:0] disp);
    logic [XLEN-1:0] seq;
    seq = pc + XLEN'(4);
    return take ? seq + {disp[XLEN-3:0], 2'b00} : seq;
  endfunction
endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (op)
      OP_RTYPE: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctrl.dst_rd = 1'b1;
          ctrl.reg_wr = 1'b1;
          ctrl.alu_op = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OP_ORI: begin
        ctrl.b_imm  = 1'b1;
        ctrl.alu_op = ALU_OR;
        ctrl.reg_wr = 1'b1;
      end
      OP_LOAD: begin
        ctrl.b_imm    = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.wb_mem   = 1'b1;
        ctrl.reg_wr   = 1'b1;
      end
      OP_STORE: begin
        ctrl.b_imm    = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.mem_wr   = 1'b1;
      end
      OP_BEQ: begin
        ctrl.alu_op    = ALU_SUB;
        ctrl.ext_sign  = 1'b1;
        ctrl.is_branch = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          we,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] bank [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (we && wa != '0) begin
      bank[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : bank[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : bank[ra_b];

  // R3
  wr_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> ((ra_a != $past(wa)) || (rd_a == $past(wd))));

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_b == '0) |-> (rd_b == '0));
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  assign y    = alu_eval(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import core_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [XLEN-1:0]  imem_addr,
  input  logic [XLEN-1:0]  imem_data,
  output logic [XLEN-1:0]  dmem_addr,
  output logic [XLEN-1:0]  dmem_wdata,
  output logic             dmem_we,
  input  logic [XLEN-1:0]  dmem_rdata
);
  localparam int AW = $clog2(NREG);

  logic [XLEN-1:0] pc_q;
  ctrl_t           ctrl;
  logic [5:0]      f_op, f_fn;
  logic [4:0]      f_rs, f_rt, f_rd;
  logic [IMMW-1:0] f_imm;
  logic [XLEN-1:0] bus_a, bus_b, imm_x, alu_b, alu_y, wb_data;
  logic            alu_zero, br_take, op_known;
  logic [4:0]      wr_idx;

  assign f_op  = imem_data[31:26];
  assign f_rs  = imem_data[25:21];
  assign f_rt  = imem_data[20:16];
  assign f_rd  = imem_data[15:11];
  assign f_fn  = imem_data[5:0];
  assign f_imm = imem_data[15:0];

  core_decode u_dec (.op(f_op), .funct(f_fn), .ctrl(ctrl));

  assign wr_idx  = ctrl.dst_rd ? f_rd : f_rt;
  assign wb_data = ctrl.wb_mem ? dmem_rdata : alu_y;

  core_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra_a(AW'(f_rs)),
    .ra_b(AW'(f_rt)),
    .wa  (AW'(wr_idx)),
    .wd  (wb_data),
    .we  (ctrl.reg_wr),
    .rd_a(bus_a),
    .rd_b(bus_b)
  );

  assign imm_x = extend_imm(f_imm, ctrl.ext_sign);
  assign alu_b = ctrl.b_imm ? imm_x : bus_b;

  core_alu #(.W(XLEN)) u_alu (
    .op  (ctrl.alu_op),
    .a   (bus_a),
    .b   (alu_b),
    .y   (alu_y),
    .zero(alu_zero)
  );

  assign br_take = ctrl.is_branch & alu_zero;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= next_pc(pc_q, br_take, imm_x);
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = {alu_y[XLEN-1:2], 2'b00};
  assign dmem_wdata = bus_b;
  assign dmem_we    = ctrl.mem_wr & ~rst;

  assign op_known = (f_op == OP_ORI) || (f_op == OP_LOAD) || (f_op == OP_STORE) ||
                    (f_op == OP_BEQ) ||
                    ((f_op == OP_RTYPE) && (f_fn == FN_ADD || f_fn == FN_SUB));

  // R1
  reset_pc_chk: assert property (@(posedge clk)
    rst |=> (imem_addr == '0));

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    !br_take |=> (imem_addr == $past(imem_addr) + 32'd4));

  // R7
  branch_pc_chk: assert property (@(posedge clk) disable iff (rst)
    br_take |=> (imem_addr == $past(imem_addr) + 32'd4 +
                 {{14{$past(imem_data[15])}}, $past(imem_data[15:0]), 2'b00}));

  // R6
  store_nowb_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !ctrl.reg_wr);

  // R9
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !op_known |-> (!dmem_we && !ctrl.reg_wr));
endmodule

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  always #2.5 clk = ~clk;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  sc_core i_sc_core (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  // reference model state
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  string       m_tag [32];
  logic [31:0] m_pc;
  string       pc_tag;
  int total = 0;
  int bad   = 0;

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                        input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_model(input logic [4:0] r, input logic [31:0] v, input string t);
    if (r != 5'd0) begin
      m_reg[r] = v;
      m_tag[r] = t;
    end else begin
      m_tag[0] = "R8";
    end
  endtask

  // compare the cycle's outputs with the model, then advance the model
  task automatic step();
    logic [31:0] ins, a, b, ea, nxt;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd;
    logic [15:0] imm;
    string       nt;
    ins = imem[m_pc[7:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    fn = ins[5:0];   imm = ins[15:0];
    check(pc_tag, "pc", imem_addr, m_pc);
    a   = m_reg[rs];
    b   = m_reg[rt];
    ea  = a + sx16(imm);
    ea  = {ea[31:2], 2'b00};
    nxt = m_pc + 32'd4;
    nt  = "R2";
    case (op)
      6'h00: begin
        check("R3", "we", {31'd0, dmem_we}, 32'd0);
        if (fn == 6'h21)      wr_model(rd, a + b, "R3");
        else if (fn == 6'h23) wr_model(rd, a - b, "R3");
        else begin
          check("R9", "we", {31'd0, dmem_we}, 32'd0);
          if (rd != 5'd0) m_tag[rd] = "R9";
          nt = "R9";
        end
      end
      6'h0D: begin
        check("R4", "we", {31'd0, dmem_we}, 32'd0);
        wr_model(rt, a | {16'h0000, imm}, "R4");
      end
      6'h23: begin
        check("R5", "we", {31'd0, dmem_we}, 32'd0);
        check("R5", "load addr", dmem_addr, ea);
        wr_model(rt, m_mem[ea[7:2]], "R5");
      end
      6'h2B: begin
        check("R6", "we", {31'd0, dmem_we}, 32'd1);
        check("R6", "store addr", dmem_addr, ea);
        check(m_tag[rt], "store data", dmem_wdata, b);
        m_mem[ea[7:2]] = b;
      end
      6'h04: begin
        check("R7", "we", {31'd0, dmem_we}, 32'd0);
        if (a == b) nxt = m_pc + 32'd4 + {sx16(imm)[29:0], 2'b00};
        nt = "R7";
      end
      default: begin
        check("R9", "we", {31'd0, dmem_we}, 32'd0);
        if (rt != 5'd0) m_tag[rt] = "R9";
        nt = "R9";
      end
    endcase
    if (dmem_we === 1'b1) dmem[dmem_addr[7:2]] = dmem_wdata;
    m_pc   = nxt;
    pc_tag = nt;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int i = 0; i < 32; i++) begin
      m_reg[i] = 32'd0;
      m_tag[i] = (i == 0) ? "R8" : "R1";
    end
    for (int i = 0; i < 64; i++) begin
      dmem[i]  = 32'h0101_0101 * 32'(i);
      m_mem[i] = 32'h0101_0101 * 32'(i);
    end
    m_pc   = 32'd0;
    pc_tag = "R1";
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "pc in reset", imem_addr, 32'd0);
    check("R1", "we in reset", {31'd0, dmem_we}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic run(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      #1;
      step();
      @(negedge clk);
    end
  endtask

  task automatic load_directed();
    imem[0]  = enc_i(6'h0D, 0, 1, 16'hFFFF);   // R4 zero extension
    imem[1]  = enc_i(6'h0D, 0, 0, 16'h1234);   // R8 write dropped
    imem[2]  = enc_i(6'h2B, 0, 1, 16'h0000);
    imem[3]  = enc_i(6'h2B, 0, 0, 16'h0004);   // R8 reads zero
    imem[4]  = enc_r(0, 1, 2, 6'h23);          // R3 wrap
    imem[5]  = enc_r(1, 1, 3, 6'h21);
    imem[6]  = enc_i(6'h2B, 0, 2, 16'h0008);
    imem[7]  = enc_i(6'h0D, 0, 5, 16'h0010);
    imem[8]  = enc_i(6'h23, 5, 4, 16'hFFF8);   // R5 negative offset
    imem[9]  = enc_i(6'h2B, 0, 4, 16'h000D);   // R5 R6 low bits dropped
    imem[10] = enc_i(6'h3F, 0, 1, 16'h0055);   // R9 unknown opcode
    imem[11] = enc_r(1, 1, 1, 6'h20);          // R9 unknown function
    imem[12] = enc_i(6'h04, 1, 2, 16'h0005);   // R7 not taken
    imem[13] = enc_i(6'h04, 1, 1, 16'h0002);   // R7 taken
    imem[14] = enc_i(6'h0D, 0, 6, 16'h0077);
    imem[15] = enc_i(6'h0D, 0, 6, 16'h0088);
    imem[16] = enc_i(6'h2B, 0, 1, 16'h0014);
    imem[17] = enc_i(6'h2B, 0, 3, 16'h0018);
    imem[18] = enc_i(6'h2B, 0, 6, 16'h001C);
    imem[19] = enc_i(6'h04, 0, 0, 16'hFFFD);   // R7 taken backward
    for (int i = 20; i < 64; i++) imem[i] = enc_i(6'h04, 0, 0, 16'hFFFF);
  endtask

  task automatic load_random();
    for (int i = 0; i < 64; i++) begin
      int k, rs, rt, rd;
      logic [15:0] imm;
      k  = int'($urandom % 10);
      rs = int'($urandom % 8);
      rt = int'($urandom % 8);
      rd = int'($urandom % 8);
      imm = 16'($urandom);
      case (k)
        0: imem[i] = enc_r(rs, rt, rd, 6'h21);
        1: imem[i] = enc_r(rs, rt, rd, 6'h23);
        2: imem[i] = enc_i(6'h0D, rs, rt, imm);
        3: imem[i] = enc_i(6'h23, rs, rt, 16'(int'($urandom % 64) - 32));
        4, 5: imem[i] = enc_i(6'h2B, rs, rt, 16'(int'($urandom % 64) - 32));
        6: imem[i] = enc_i(6'h04, rs, rt, 16'(int'($urandom % 12) - 5));
        7: imem[i] = enc_r(rs, rt, rd, 6'h25);
        8: imem[i] = enc_i(6'h08, rs, rt, imm);
        default: imem[i] = enc_i(6'h0D, 0, rt, imm);
      endcase
    end
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    load_directed();
    do_reset();
    run(40);
    for (int r = 0; r < 20; r++) begin
      load_random();
      do_reset();
      run(150);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule